// File: doc/BRIEF.md
# Link Speed Retrain Sequencer

This block runs once after reset on a PCI Express root port. It decides whether the link is running slower than it could and, if so, asks the port to retrain. It looks at a 5-bit link-state input. The link counts as up only in the L0 state. It reaches the port's capability registers through a small 16-bit register request channel. If the link is up, the port supports more than the lowest rate, and the link currently runs at the lowest rate, the sequencer sets the retrain-link bit with a read-modify-write of link control. It then waits in two phases. First it waits for link training to end, then for the link to be up again. Each phase has its own timeout.

Both timeout lengths and the gap between polls are parameters counted in clock cycles. Silicon uses values near one second and 100 microseconds; a bench can shorten them. Every path through the flow ends with `done` high, including the early exits. The two timeout flags report which wait phase, if any, ran out.

The request channel is valid/ready. The sequencer raises `req_valid` and holds the address, direction and write data unchanged until `req_ready` is seen high at a clock edge. Each accepted read is answered by exactly one `rsp_valid` pulse, one or more cycles later. Responses have no back-pressure: the sequencer always accepts them and never has more than one read outstanding. Writes get no response.

Top module: `link_retrain_seq`

## Requirements
- R1: The link is up only when `link_state` equals 5'h0F. If the link is not up in the first cycle after reset, the sequencer goes to done without issuing any request, and both timeout flags stay low.
- R2: The first request is a read of link capabilities at CAP_BASE+0x0C. If its supported-speed field (bits 3:0) is 1 or less, the sequencer finishes with no write and no flag.
- R3: The next read is link status at CAP_BASE+0x12. If its current-speed field (bits 3:0) is not 1, the sequencer finishes with no write and no flag.
- R4: Otherwise the sequencer reads link control at CAP_BASE+0x10. It writes the same value back to CAP_BASE+0x10 with bit 5 set and every other bit unchanged. This is the only write of the whole sequence.
- R5: In phase one the sequencer reads link status repeatedly. A result with the training bit (bit 11) clear moves it to phase two without setting `train_timeout`.
- R6: A phase-one result that still shows bit 11 set, arriving once TIMEOUT_CYC cycles have passed since the write, sets `train_timeout`. The sequencer still goes on to phase two.
- R7: Phase two finishes as soon as the link is seen up. If the link is not up after TIMEOUT_CYC cycles, `linkup_timeout` is set together with `done`.
- R8: Successive phase-one status reads are accepted more than POLL_CYC cycles apart.
- R9: A request that is not yet accepted keeps `req_valid`, `req_addr`, `req_we` and `req_wdata` stable. Every accepted read gets exactly one response.
- R10: Under reset, `done`, the two flags and `req_valid` are low. Once `done` is high it stays high until reset, and no further request is issued.
- R11: A phase-one result with bit 11 clear counts as success even when the phase timeout has already expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the sequence starts when it is released |
| link_state | input | 5 | Current link state; 5'h0F means L0 |
| req_valid | output | 1 | Register request present |
| req_ready | input | 1 | Register target accepts the request |
| req_we | output | 1 | 1 = write, 0 = read |
| req_addr | output | ADDR_W | Byte address of the 16-bit register |
| req_wdata | output | DATA_W | Write data |
| rsp_valid | input | 1 | Read data valid, one pulse per accepted read |
| rsp_data | input | DATA_W | Read data |
| done | output | 1 | Sequence finished (sticky) |
| train_timeout | output | 1 | Training did not end within the timeout |
| linkup_timeout | output | 1 | Link did not come up within the timeout |

## Verification
In phase one, the end of training and the expiry of the phase timeout can land on the same status result. The decision logic must then choose between success and a flagged timeout. The bench provokes this by making the training bit clear exactly when the timeout length has elapsed since the write. The first poll that sees the bit clear therefore arrives with the timer already expired. The bench judges the case by requiring `train_timeout` to stay low and phase two to follow as normal. Random ready and response latency move the poll instants so that the overlap falls at different offsets.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

  // register offsets from the capability base
  localparam int OFS_CAP = 'h0C;
  localparam int OFS_CTL = 'h10;
  localparam int OFS_STA = 'h12;

  // field positions
  localparam int BIT_RETRAIN  = 5;
  localparam int BIT_TRAINING = 11;
  localparam int SPEED_LSB    = 0;
  localparam int SPEED_W      = 4;

  localparam logic [SPEED_W-1:0] SPEED_LOWEST = 4'd1;
  localparam logic [4:0]         LINK_L0      = 5'h0F;

  typedef enum logic [3:0] {
    ST_START,
    ST_CAP_RQ,
    ST_CAP_RS,
    ST_STA_RQ,
    ST_STA_RS,
    ST_CTL_RQ,
    ST_CTL_RS,
    ST_CTL_WR,
    ST_TR_RQ,
    ST_TR_RS,
    ST_TR_GAP,
    ST_UP_CHK,
    ST_UP_GAP,
    ST_DONE
  } seq_state_t;

endpackage

// File: rtl/lrs_timer.sv
module lrs_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic expired
);
  localparam int unsigned CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (clear)      cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIM);
endmodule

// File: rtl/lrs_ctrl.sv
module lrs_ctrl
  import lrs_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 16,
  parameter int CAP_BASE = 'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        link_state,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_we,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              phase_expired,
  input  logic              gap_expired,
  output logic              phase_clr,
  output logic              gap_clr,
  output logic              done,
  output logic              train_timeout,
  output logic              linkup_timeout
);
  localparam logic [ADDR_W-1:0] A_CAP = ADDR_W'(CAP_BASE + OFS_CAP);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CAP_BASE + OFS_CTL);
  localparam logic [ADDR_W-1:0] A_STA = ADDR_W'(CAP_BASE + OFS_STA);
  localparam logic [DATA_W-1:0] RETRAIN_MASK = DATA_W'(1) << BIT_RETRAIN;

  seq_state_t state, nxt;
  logic [DATA_W-1:0] ctl_q;
  logic tr_q, up_q, grab_ctl, set_tr, set_up, link_up;
  logic [SPEED_W-1:0] speed;

  assign link_up = (link_state == LINK_L0);
  assign speed   = rsp_data[SPEED_LSB +: SPEED_W];

  always_comb begin
    nxt       = state;
    phase_clr = 1'b0;
    gap_clr   = 1'b0;
    set_tr    = 1'b0;
    set_up    = 1'b0;
    grab_ctl  = 1'b0;
    case (state)
      ST_START:  nxt = link_up ? ST_CAP_RQ : ST_DONE;
      ST_CAP_RQ: if (req_ready) nxt = ST_CAP_RS;
      ST_CAP_RS: if (rsp_valid) nxt = (speed > SPEED_LOWEST) ? ST_STA_RQ : ST_DONE;
      ST_STA_RQ: if (req_ready) nxt = ST_STA_RS;
      ST_STA_RS: if (rsp_valid) nxt = (speed == SPEED_LOWEST) ? ST_CTL_RQ : ST_DONE;
      ST_CTL_RQ: if (req_ready) nxt = ST_CTL_RS;
      ST_CTL_RS: if (rsp_valid) begin
        grab_ctl = 1'b1;
        nxt      = ST_CTL_WR;
      end
      ST_CTL_WR: if (req_ready) begin
        nxt       = ST_TR_RQ;
        phase_clr = 1'b1;
      end
      ST_TR_RQ:  if (req_ready) nxt = ST_TR_RS;
      ST_TR_RS:  if (rsp_valid) begin
        // a finished result wins over an expired timer
        if (!rsp_data[BIT_TRAINING]) begin
          nxt       = ST_UP_CHK;
          phase_clr = 1'b1;
        end else if (phase_expired) begin
          set_tr    = 1'b1;
          nxt       = ST_UP_CHK;
          phase_clr = 1'b1;
        end else begin
          nxt     = ST_TR_GAP;
          gap_clr = 1'b1;
        end
      end
      ST_TR_GAP: if (gap_expired) nxt = ST_TR_RQ;
      ST_UP_CHK: begin
        if (link_up) nxt = ST_DONE;
        else if (phase_expired) begin
          set_up = 1'b1;
          nxt    = ST_DONE;
        end else begin
          nxt     = ST_UP_GAP;
          gap_clr = 1'b1;
        end
      end
      ST_UP_GAP: if (gap_expired) nxt = ST_UP_CHK;
      default:   nxt = ST_DONE;
    endcase
  end

  always_comb begin
    req_valid = 1'b0;
    req_we    = 1'b0;
    req_addr  = '0;
    case (state)
      ST_CAP_RQ: begin req_valid = 1'b1; req_addr = A_CAP; end
      ST_STA_RQ,
      ST_TR_RQ:  begin req_valid = 1'b1; req_addr = A_STA; end
      ST_CTL_RQ: begin req_valid = 1'b1; req_addr = A_CTL; end
      ST_CTL_WR: begin req_valid = 1'b1; req_addr = A_CTL; req_we = 1'b1; end
      default: ;
    endcase
  end

  assign req_wdata = ctl_q | RETRAIN_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_START;
      ctl_q <= '0;
      tr_q  <= 1'b0;
      up_q  <= 1'b0;
    end else begin
      state <= nxt;
      if (grab_ctl) ctl_q <= rsp_data;
      if (set_tr)   tr_q  <= 1'b1;
      if (set_up)   up_q  <= 1'b1;
    end
  end

  assign done           = (state == ST_DONE);
  assign train_timeout  = tr_q;
  assign linkup_timeout = up_q;
endmodule

// File: rtl/link_retrain_seq.sv
module link_retrain_seq #(
  parameter int          ADDR_W      = 12,
  parameter int          DATA_W      = 16,
  parameter int          CAP_BASE    = 'h80,
  parameter int unsigned TIMEOUT_CYC = 125_000_000,
  parameter int unsigned POLL_CYC    = 12_500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        link_state,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_we,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              done,
  output logic              train_timeout,
  output logic              linkup_timeout
);
  logic phase_clr, gap_clr, phase_expired, gap_expired;

  lrs_timer #(.LIMIT(TIMEOUT_CYC)) u_phase_tmr (
    .clk(clk), .rst_n(rst_n), .clear(phase_clr), .expired(phase_expired)
  );

  lrs_timer #(.LIMIT(POLL_CYC)) u_gap_tmr (
    .clk(clk), .rst_n(rst_n), .clear(gap_clr), .expired(gap_expired)
  );

  lrs_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CAP_BASE(CAP_BASE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .link_state(link_state),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .phase_expired(phase_expired), .gap_expired(gap_expired),
    .phase_clr(phase_clr), .gap_clr(gap_clr),
    .done(done), .train_timeout(train_timeout), .linkup_timeout(linkup_timeout)
  );
endmodule

// File: rtl/lrs_checker.sv
module lrs_checker #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 16,
  parameter int CAP_BASE = 'h80
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_we,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              done,
  input logic              train_timeout,
  input logic              linkup_timeout
);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CAP_BASE + 'h10);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_we) && $stable(req_wdata));

  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R10
  quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid);

  // R4
  write_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_we |-> (req_addr == A_CTL) && req_wdata[5]);

  // R6
  train_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    train_timeout |=> train_timeout);

  // R6
  train_flag_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(train_timeout) |-> !done);

  // R7
  up_flag_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    linkup_timeout |-> done);
endmodule

bind link_retrain_seq lrs_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CAP_BASE(CAP_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .done(done),
  .train_timeout(train_timeout), .linkup_timeout(linkup_timeout)
);

// File: tb/tb_link_retrain_seq.sv
`timescale 1ns/1ps
module tb_link_retrain_seq;
  localparam int TMO  = 400;
  localparam int POLL = 20;
  localparam int BASE = 'h80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  link_state = 5'h00;
  logic        req_valid, req_we;
  logic        req_ready = 1'b0;
  logic [11:0] req_addr;
  logic [15:0] req_wdata;
  logic        rsp_valid = 1'b0;
  logic [15:0] rsp_data = '0;
  logic        done, train_timeout, linkup_timeout;

  always #4 clk = ~clk;

  link_retrain_seq #(.ADDR_W(12), .DATA_W(16), .CAP_BASE(BASE),
                     .TIMEOUT_CYC(TMO), .POLL_CYC(POLL)) dut (
    .clk(clk), .rst_n(rst_n), .link_state(link_state),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .done(done), .train_timeout(train_timeout), .linkup_timeout(linkup_timeout)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // target model configuration
  int cfg_sls, cfg_cls, cfg_lt_delay, cfg_up_delay, cfg_ready_pct, cfg_maxlat;
  logic [15:0] cfg_ctl, cfg_hi;
  // observation log
  int n_rd, n_wr, n_rsp, n_bad, n_sta_post, min_gap, wr_cyc, last_sta, cyc = 0;
  bit wr_seen;
  logic [11:0] wr_addr;
  logic [15:0] wr_data;
  int pend, cnt;
  logic [15:0] pend_data;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_retrain(input bit up0, input int sls, input int cls);
    return up0 && (sls > 1) && (cls == 1);
  endfunction

  function automatic logic [15:0] read_model(input logic [11:0] a);
    bit lt;
    lt = wr_seen && (cfg_lt_delay < 0 || (cyc - wr_cyc) < cfg_lt_delay);
    if (a == 12'(BASE + 'h0C)) return {cfg_hi[15:4], 4'(cfg_sls)};
    if (a == 12'(BASE + 'h12)) return {4'h3, lt, 7'h15, 4'(cfg_cls)};
    if (a == 12'(BASE + 'h10)) return cfg_ctl;
    return 16'h0;
  endfunction

  // register target and link model
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst_n) begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        pend = 0;
      end else begin
        bit r;
        rsp_valid = 1'b0;
        if (pend != 0) begin
          cnt--;
          if (cnt == 0) begin
            rsp_valid = 1'b1;
            rsp_data  = pend_data;
            pend = 0;
            n_rsp++;
          end
        end
        if (wr_seen && cfg_up_delay >= 0 && (cyc - wr_cyc) >= cfg_up_delay)
          link_state = 5'h0F;
        r = ($urandom_range(99) < cfg_ready_pct);
        req_ready = r;
        if (req_valid && r) begin
          if (req_we) begin
            n_wr++;
            wr_addr = req_addr;
            wr_data = req_wdata;
            wr_seen = 1'b1;
            wr_cyc = cyc;
            link_state = 5'h0B;
          end else begin
            n_rd++;
            if (req_addr != 12'(BASE + 'h0C) && req_addr != 12'(BASE + 'h10) &&
                req_addr != 12'(BASE + 'h12)) n_bad++;
            if (wr_seen && req_addr == 12'(BASE + 'h12)) begin
              n_sta_post++;
              if (last_sta >= 0 && (cyc - last_sta) < min_gap) min_gap = cyc - last_sta;
              last_sta = cyc;
            end
            pend = 1;
            cnt = $urandom_range(cfg_maxlat, 1);
            pend_data = read_model(req_addr);
          end
        end
      end
    end
  end

  task automatic run_case(input bit up0, input int sls, input int cls, input int ltd,
                          input int upd, input logic [15:0] ctl, input int rdy,
                          input int lat, input string trtag, input bit chk_reset);
    string ptag;
    bit ew;
    int k, s_rd, s_wr;
    rst_n = 1'b0;
    cfg_sls = sls; cfg_cls = cls; cfg_lt_delay = ltd; cfg_up_delay = upd;
    cfg_ctl = ctl; cfg_ready_pct = rdy; cfg_maxlat = lat;
    cfg_hi = 16'($urandom);
    link_state = up0 ? 5'h0F : 5'(5'h10 + $urandom_range(14));
    n_rd = 0; n_wr = 0; n_rsp = 0; n_bad = 0; n_sta_post = 0;
    min_gap = 1 << 30; last_sta = -1; wr_seen = 1'b0;
    repeat (3) @(negedge clk);
    if (chk_reset) begin
      // R10 reset state
      check(!done && !req_valid && !train_timeout && !linkup_timeout, "R10",
            "outputs under reset", {done, req_valid, train_timeout, linkup_timeout}, 0);
    end
    rst_n = 1'b1;
    k = 0;
    while (!done && k < 4000) begin @(negedge clk); k++; end
    check(done, "R10", "done reached", done, 1);
    ew = exp_retrain(up0, sls, cls);
    ptag = !up0 ? "R1" : (sls <= 1) ? "R2" : (cls != 1) ? "R3" : "R4";
    check(n_wr == int'(ew), ptag, "write count", n_wr, ew);
    if (ew) begin
      check(wr_addr == 12'(BASE + 'h10), "R4", "write address", wr_addr, BASE + 'h10);
      check(wr_data == (ctl | 16'h0020), "R4", "write data", wr_data, ctl | 16'h0020);
      check(train_timeout == (ltd < 0),
            (trtag != "") ? trtag : ((ltd < 0) ? "R6" : "R5"),
            "train_timeout", train_timeout, ltd < 0);
      check(linkup_timeout == (upd < 0), "R7", "linkup_timeout", linkup_timeout, upd < 0);
      if (n_sta_post >= 2)
        check(min_gap > POLL, "R8", "poll spacing", min_gap, POLL + 1);
    end else begin
      check(!train_timeout && !linkup_timeout, ptag, "flags on early exit",
            {train_timeout, linkup_timeout}, 0);
    end
    if (!up0) check(n_rd == 0, "R1", "reads with link down", n_rd, 0);
    check(n_bad == 0, "R2", "reads to unexpected address", n_bad, 0);
    check(n_rsp == n_rd, "R9", "responses per read", n_rsp, n_rd);
    s_rd = n_rd; s_wr = n_wr;
    repeat (20) @(negedge clk);
    check(done && n_rd == s_rd && n_wr == s_wr, "R10", "quiet and done after finish",
          n_rd + n_wr, s_rd + s_wr);
  endtask

  initial begin
    void'($urandom(32'd5551));
    // directed
    run_case(0, 3, 1, 10, 10, 16'h1234, 100, 1, "", 1);          // R1
    run_case(1, 1, 1, 10, 10, 16'h1234, 80, 3, "", 0);           // R2
    run_case(1, 0, 1, 10, 10, 16'h1234, 80, 3, "", 0);           // R2
    run_case(1, 3, 2, 10, 10, 16'h1234, 70, 2, "", 0);           // R3
    run_case(1, 2, 1, 30, 50, 16'hFFDF, 90, 4, "", 0);           // R4, R5
    run_case(1, 4, 1, 0, 0, 16'h0021, 100, 1, "", 0);            // R4 bit already set
    run_case(1, 3, 1, -1, 40, 16'h0A00, 60, 3, "", 0);           // R6
    run_case(1, 3, 1, 25, -1, 16'h0040, 60, 3, "", 0);           // R7
    run_case(1, 3, 1, -1, -1, 16'h8001, 100, 2, "", 0);          // R6 and R7
    run_case(1, 3, 1, TMO, 5, 16'h0100, 100, 1, "R11", 0);       // R11 coincidence
    run_case(1, 3, 1, TMO - 1, 5, 16'h0100, 100, 3, "R11", 0);   // R11 near edge
    // constrained random
    for (int i = 0; i < 30; i++) begin
      bit up0;
      int sls, cls, ltd, upd;
      up0 = ($urandom_range(99) < 85);
      sls = $urandom_range(4);
      cls = ($urandom_range(99) < 70) ? 1 : $urandom_range(4);
      ltd = ($urandom_range(99) < 25) ? -1 : $urandom_range(80);
      upd = ($urandom_range(99) < 25) ? -1 : $urandom_range(120);
      run_case(up0, sls, cls, ltd, upd, 16'($urandom) & 16'hFFDF,
               $urandom_range(100, 50), $urandom_range(4, 1), "", 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog expired act=%0d exp=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule